// File: doc/BRIEF.md
# Flash Command Controller with Block Lock

This block is the command and status front end of a block-structured on-chip flash array. A CPU sends it single-byte command writes and address/data writes. The block decodes the command sequences, runs auto-program and auto-erase operations against a behavioural byte array, and keeps one lock bit per block. A global lock-disable input can override all lock bits. Operation latency comes from a cycle counter with separate program and erase lengths. A status register and a ready output report progress and errors.

Reads are combinational from `addr_i`. The last read-mode command decides what `rdata_o` returns: array bytes, the status register, or the lock bit of the addressed block. Each command byte goes in `wdata_i` on a cycle where `wr_i` is high. For a two-write sequence, the second write carries the target address in `addr_i` and either the data byte or the confirm byte 0xD0 in `wdata_i`. The block number is `addr_i[ADDR_W-1:OFS_W]`, where `OFS_W = log2(BLOCK_BYTES)`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ready_o` is 1, the status register is 0x80, every array byte reads 0xFF in array-read mode, array-read mode is selected, and every lock bit is 1 (unlocked).
- R2: Command 0x70 makes reads return the status register. Command 0x50 clears status bit 5 (erase error) and status bit 4 (program error).
- R3: Command 0x40 followed by a write of data D to address A holds `ready_o` low for exactly PROG_CYCLES cycles. After that, the byte at A equals its old value AND D.
- R4: A program that tries to turn a 0 bit into 1 sets status bit 4. The byte still ends up as old AND data.
- R5: Command 0x20 followed by a write of 0xD0 to any address in a block holds `ready_o` low for exactly ERASE_CYCLES cycles and then sets every byte of that block to 0xFF. Any confirm byte other than 0xD0 cancels the erase: nothing changes, `ready_o` stays 1, and array-read mode is selected.
- R6: Command 0x77 followed by a write of 0xD0 drives the lock bit of the addressed block to 0, with `ready_o` low for PROG_CYCLES cycles. Command 0x71 makes reads return the addressed block's lock bit in bit 0, with bits 7..1 at 0.
- R7: With `lock_dis_i` at 0, an erase aimed at a block whose lock bit is 0 is refused and sets status bit 5. A program aimed at such a block is refused and sets status bit 4. A refused operation never drops `ready_o` and leaves the array unchanged.
- R8: With `lock_dis_i` at 1, locked blocks accept program and erase. An erase in this mode also sets that block's lock bit back to 1.
- R9: `ready_o` equals status bit 7. Once a program, erase or lock-program sequence is complete, reads return the status register.
- R10: While `ready_o` is 0, every command write except 0x70 is ignored.
- R11: Command 0xFF selects array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | Byte address for writes and reads |
| wdata_i | input | 8 | Command, confirm or program data byte |
| lock_dis_i | input | 1 | 1 = ignore all lock bits |
| rdata_o | output | 8 | Read data selected by the read mode |
| ready_o | output | 1 | 1 = idle, 0 = operation running |

## Verification
The assertions assume that `wr_i` is a clean single-cycle strobe sampled at the rising edge. They also assume that `addr_i` and `wdata_i` are stable whenever `wr_i` is high, and that `lock_dis_i` changes only while the block is idle. The bench drives every input on the falling edge. It changes `lock_dis_i` only after `ready_o` has returned high. During busy windows it sends only whole write cycles, so every stimulus stays inside those assumptions.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] CMD_PROGRAM      = 8'h40;
  localparam logic [7:0] CMD_ERASE        = 8'h20;
  localparam logic [7:0] CMD_LOCK_PGM     = 8'h77;
  localparam logic [7:0] CMD_READ_LOCK    = 8'h71;
  localparam logic [7:0] CMD_CONFIRM      = 8'hD0;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_LOCK} rd_mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_PROG_ARG, ST_ERASE_ARG, ST_LOCK_ARG, ST_BUSY} seq_state_e;
  typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_LOCK} op_e;
endpackage

// File: rtl/flash_lock_bank.sv
module flash_lock_bank #(
  parameter int NUM_BLOCKS = 4,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] rd_blk_i,
  output logic             rd_lock_o,
  input  logic [BLK_W-1:0] op_blk_i,
  input  logic             lock_pgm_i,
  input  logic             erase_unlock_i
);
  logic [NUM_BLOCKS-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '1;
    end else if (lock_pgm_i) begin
      lock_q[op_blk_i] <= 1'b0;
    end else if (erase_unlock_i) begin
      lock_q[op_blk_i] <= 1'b1;
    end
  end

  assign rd_lock_o = lock_q[rd_blk_i];

  assert_lock_pgm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_pgm_i |=> lock_q[$past(op_blk_i)] == 1'b0);
  assert_erase_unlock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_unlock_i && !lock_pgm_i) |=> lock_q[$past(op_blk_i)] == 1'b1);
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_BYTES = 16,
  localparam int DEPTH  = NUM_BLOCKS * BLOCK_BYTES,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int OFS_W  = $clog2(BLOCK_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        chk_data_i,
  output logic [7:0]        rd_data_o,
  output logic              prog_bad_o,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [7:0]        op_data_i
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((i >> OFS_W) == (int'(op_addr_i) >> OFS_W)) mem_q[i] <= 8'hFF;
      end
    end else if (prog_i) begin
      mem_q[op_addr_i] <= mem_q[op_addr_i] & op_data_i;
    end
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  // program can only clear bits
  assign prog_bad_o = |(chk_data_i & ~mem_q[rd_addr_i]);

  assert_prog_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && !erase_i) |=> (mem_q[$past(op_addr_i)] & ~$past(op_data_i)) == 8'h00);
  assert_erase_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> mem_q[$past(op_addr_i)] == 8'hFF);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int PROG_CYCLES  = 5,
  parameter int ERASE_CYCLES = 12,
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              lock_bit_i,
  input  logic              lock_dis_i,
  input  logic              prog_bad_i,
  output logic              prog_o,
  output logic              erase_o,
  output logic              lock_pgm_o,
  output logic              erase_unlock_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output logic [7:0]        status_o,
  output rd_mode_e          rd_mode_o
);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  seq_state_e        state_q;
  op_e               op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              unlock_q;
  logic              ready_q, err_erase_q, err_prog_q;
  rd_mode_e          mode_q;
  logic              tgt_locked, last_cyc;

  assign tgt_locked = !lock_bit_i && !lock_dis_i;
  assign last_cyc   = (state_q == ST_BUSY) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_PROG;
      cnt_q       <= '0;
      addr_q      <= '0;
      data_q      <= 8'hFF;
      unlock_q    <= 1'b0;
      ready_q     <= 1'b1;
      err_erase_q <= 1'b0;
      err_prog_q  <= 1'b0;
      mode_q      <= RD_ARRAY;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_i) begin
          unique case (wdata_i)
            CMD_READ_ARRAY:   mode_q <= RD_ARRAY;
            CMD_READ_STATUS:  mode_q <= RD_STATUS;
            CMD_READ_LOCK:    mode_q <= RD_LOCK;
            CMD_CLEAR_STATUS: begin
              err_erase_q <= 1'b0;
              err_prog_q  <= 1'b0;
            end
            CMD_PROGRAM:      state_q <= ST_PROG_ARG;
            CMD_ERASE:        state_q <= ST_ERASE_ARG;
            CMD_LOCK_PGM:     state_q <= ST_LOCK_ARG;
            default: ;
          endcase
        end
        ST_PROG_ARG: if (wr_i) begin
          mode_q <= RD_STATUS;
          if (tgt_locked) begin
            err_prog_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            if (prog_bad_i) err_prog_q <= 1'b1;
            op_q     <= OP_PROG;
            addr_q   <= addr_i;
            data_q   <= wdata_i;
            unlock_q <= 1'b0;
            cnt_q    <= PROG_LOAD;
            ready_q  <= 1'b0;
            state_q  <= ST_BUSY;
          end
        end
        ST_ERASE_ARG: if (wr_i) begin
          if (wdata_i != CMD_CONFIRM) begin
            mode_q  <= RD_ARRAY;
            state_q <= ST_IDLE;
          end else begin
            mode_q <= RD_STATUS;
            if (tgt_locked) begin
              err_erase_q <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              op_q     <= OP_ERASE;
              addr_q   <= addr_i;
              unlock_q <= lock_dis_i;
              cnt_q    <= ERASE_LOAD;
              ready_q  <= 1'b0;
              state_q  <= ST_BUSY;
            end
          end
        end
        ST_LOCK_ARG: if (wr_i) begin
          if (wdata_i != CMD_CONFIRM) begin
            mode_q  <= RD_ARRAY;
            state_q <= ST_IDLE;
          end else begin
            mode_q   <= RD_STATUS;
            op_q     <= OP_LOCK;
            addr_q   <= addr_i;
            unlock_q <= 1'b0;
            cnt_q    <= PROG_LOAD;
            ready_q  <= 1'b0;
            state_q  <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (wr_i && wdata_i == CMD_READ_STATUS) mode_q <= RD_STATUS;
          if (cnt_q == '0) begin
            ready_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign prog_o         = last_cyc && (op_q == OP_PROG);
  assign erase_o        = last_cyc && (op_q == OP_ERASE);
  assign lock_pgm_o     = last_cyc && (op_q == OP_LOCK);
  assign erase_unlock_o = erase_o && unlock_q;
  assign op_addr_o      = addr_q;
  assign op_data_o      = data_q;
  assign status_o       = {ready_q, 1'b0, err_erase_q, err_prog_q, 4'b0000};
  assign rd_mode_o      = mode_q;

  assert_busy_status_view_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY) |-> (mode_q == RD_STATUS && !ready_q));
  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && wr_i && wdata_i == CMD_CLEAR_STATUS) |=> (!err_erase_q && !err_prog_q));
  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && wr_i) |=> ($stable(addr_q) && $stable(op_q)));
  assert_erase_refuse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERASE_ARG && wr_i && wdata_i == CMD_CONFIRM && tgt_locked)
      |=> (err_erase_q && ready_q && state_q == ST_IDLE));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_BYTES  = 16,
  parameter int PROG_CYCLES  = 5,
  parameter int ERASE_CYCLES = 12,
  localparam int DEPTH  = NUM_BLOCKS * BLOCK_BYTES,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int OFS_W  = $clog2(BLOCK_BYTES),
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              lock_dis_i,
  output logic [7:0]        rdata_o,
  output logic              ready_o
);
  logic              prog, erase, lock_pgm, erase_unlock, prog_bad, rd_lock;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data, status, arr_data;
  logic [BLK_W-1:0]  rd_blk, op_blk;
  rd_mode_e          rd_mode;

  assign rd_blk = BLK_W'(addr_i >> OFS_W);
  assign op_blk = BLK_W'(op_addr >> OFS_W);

  flash_seq #(
    .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .lock_bit_i(rd_lock), .lock_dis_i, .prog_bad_i(prog_bad),
    .prog_o(prog), .erase_o(erase), .lock_pgm_o(lock_pgm),
    .erase_unlock_o(erase_unlock), .op_addr_o(op_addr), .op_data_o(op_data),
    .status_o(status), .rd_mode_o(rd_mode)
  );

  flash_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_lock (
    .clk_i, .rst_ni, .rd_blk_i(rd_blk), .rd_lock_o(rd_lock),
    .op_blk_i(op_blk), .lock_pgm_i(lock_pgm), .erase_unlock_i(erase_unlock)
  );

  flash_array_model #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_array (
    .clk_i, .rst_ni, .rd_addr_i(addr_i), .chk_data_i(wdata_i),
    .rd_data_o(arr_data), .prog_bad_o(prog_bad),
    .prog_i(prog), .erase_i(erase), .op_addr_i(op_addr), .op_data_i(op_data)
  );

  always_comb begin
    unique case (rd_mode)
      RD_STATUS: rdata_o = status;
      RD_LOCK:   rdata_o = {7'b0, rd_lock};
      default:   rdata_o = arr_data;
    endcase
  end

  assign ready_o = status[7];

  assert_one_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog, erase, lock_pgm}));
  assert_commit_ends_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog || erase || lock_pgm) |=> ready_o);
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int NB = 4, BB = 16, PC = 5, EC = 12;
  localparam int AW = $clog2(NB * BB);

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, ldis = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = 8'h00, rdata;
  logic ready;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .lock_dis_i(ldis), .rdata_o(rdata), .ready_o(ready));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); wdata = d[7:0];
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = AW'(a); #1; v = int'(rdata);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    int v;
    chk("R1 ready", int'(ready), 1);
    rd(7, v); chk("R1 array", v, 8'hFF);
    bus_wr(0, 8'h71); rd(0, v); chk("R1 lock", v, 1);
    bus_wr(0, 8'h70); rd(0, v); chk("R1 status", v, 8'h80);
  endtask

  task automatic t_program;
    int v, n;
    bus_wr(0, 8'h40); bus_wr(5, 8'h3C);
    busy_len(n); chk("R3 busy len", n, PC);
    rd(5, v); chk("R9 status view", v, 8'h80);
    bus_wr(0, 8'hFF); rd(5, v); chk("R3 data", v, 8'h3C);
    chk("R11 array mode", v, 8'h3C);
  endtask

  task automatic t_program_bad;
    int v, n;
    bus_wr(0, 8'h40); bus_wr(5, 8'hF0); busy_len(n);
    rd(5, v); chk("R4 status", v, 8'h90);
    bus_wr(0, 8'hFF); rd(5, v); chk("R4 data", v, 8'h30);
    bus_wr(0, 8'h50); bus_wr(0, 8'h70); rd(0, v); chk("R2 clear", v, 8'h80);
  endtask

  task automatic t_busy_ignore;
    int v, n;
    bus_wr(0, 8'h40); bus_wr(6, 8'h0F);
    chk("R9 ready low", int'(ready), 0);
    bus_wr(0, 8'hFF);
    rd(6, v); chk("R10 mode kept", v, 8'h00);
    bus_wr(0, 8'h20); bus_wr(0, 8'hD0);
    busy_len(n);
    rd(0, v); chk("R10 status", v, 8'h80);
    bus_wr(0, 8'hFF);
    rd(6, v); chk("R10 no erase a", v, 8'h0F);
    rd(5, v); chk("R10 no erase b", v, 8'h30);
  endtask

  task automatic t_erase;
    int v, n, bad;
    bus_wr(0, 8'h20); bus_wr(3, 8'hD0);
    busy_len(n); chk("R5 busy len", n, EC);
    bus_wr(0, 8'hFF);
    bad = 0;
    for (int i = 0; i < BB; i++) begin rd(i, v); if (v != 8'hFF) bad++; end
    chk("R5 block erased", bad, 0);
  endtask

  task automatic t_erase_abort;
    int v, n;
    bus_wr(0, 8'h40); bus_wr(20, 8'h55); busy_len(n);
    bus_wr(0, 8'h20); bus_wr(16, 8'h33);
    chk("R5 abort ready", int'(ready), 1);
    rd(20, v); chk("R5 abort data", v, 8'h55);
  endtask

  task automatic t_lock;
    int v, n;
    bus_wr(0, 8'h77); bus_wr(16, 8'hD0);
    busy_len(n); chk("R6 busy len", n, PC);
    bus_wr(0, 8'h71);
    rd(16, v); chk("R6 locked", v, 0);
    rd(0, v); chk("R6 other", v, 1);
  endtask

  task automatic t_refuse;
    int v;
    bus_wr(0, 8'h20); bus_wr(17, 8'hD0);
    chk("R7 no busy erase", int'(ready), 1);
    rd(0, v); chk("R7 erase err", v, 8'hA0);
    bus_wr(0, 8'h40); bus_wr(20, 8'h00);
    chk("R7 no busy prog", int'(ready), 1);
    rd(0, v); chk("R7 prog err", v, 8'hB0);
    bus_wr(0, 8'hFF); rd(20, v); chk("R7 data kept", v, 8'h55);
    bus_wr(0, 8'h50); bus_wr(0, 8'h70); rd(0, v); chk("R2 clear both", v, 8'h80);
  endtask

  task automatic t_override;
    int v, n;
    ldis = 1'b1;
    bus_wr(0, 8'h40); bus_wr(21, 8'h0F); busy_len(n);
    bus_wr(0, 8'hFF); rd(21, v); chk("R8 prog ok", v, 8'h0F);
    bus_wr(0, 8'h20); bus_wr(18, 8'hD0);
    busy_len(n); chk("R8 erase len", n, EC);
    ldis = 1'b0;
    bus_wr(0, 8'hFF); rd(20, v); chk("R8 erased", v, 8'hFF);
    bus_wr(0, 8'h71); rd(16, v); chk("R8 unlocked", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_program_bad();
    t_busy_ignore();
    t_erase();
    t_erase_abort();
    t_lock();
    t_refuse();
    t_override();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule